// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital front end of an 8-bit voltage-output DAC. A host loads it through a three-wire serial port. Chip select is active low and frames each transfer. The data line is sampled on every rising edge of the serial clock while chip select is low. A complete transfer is a 16-bit command word. When chip select returns high, the word is checked and decoded. A valid word either loads a new converter code or places the output in a powered-down state with one of three pull-down strengths.

The serial pins run asynchronously to the block's clock. They are brought in through synchronizer flops, and the block acts on edges it sees on the synchronized copies. The host's serial clock must therefore be slower than the block clock, with each level held for at least three block-clock cycles. A word is applied only when exactly 16 serial clock rising edges arrived inside the frame. Any other count discards the word, and the previous setting is kept.

Top module: `serial_dac_ctrl`

## Requirements
- R1: A frame opens on the falling edge of `cs_ni`. While `cs_ni` is low, `din_i` is captured on each rising edge of `sclk_i`, most significant bit first. Activity on `sclk_i` and `din_i` while `cs_ni` is high has no effect on the outputs.
- R2: The outputs change only on the rising edge of `cs_ni` that closes a valid frame. During a frame the outputs keep their previous values.
- R3: A frame closed after fewer than 16 rising edges of `sclk_i` is discarded, including a frame with no edges at all. All outputs stay unchanged.
- R4: The bit counter stops at 16. A frame that receives more than 16 rising edges of `sclk_i` is discarded, and all outputs stay unchanged.
- R5: Word bit 0 is the last bit shifted in. Bits 13:12 hold the mode and bits 11:4 hold the converter code. Bits 15:14 and 3:0 are ignored.
- R6: Mode 00 selects normal operation. `code_o` takes bits 11:4, `shdn_o` goes to 0 and `pd_sel_o` goes to 00.
- R7: Modes 01, 10 and 11 select shutdown. `shdn_o` goes to 1, `code_o` reads 0, and `pd_sel_o` equals the mode value: 01 selects the 1 kOhm pull-down, 10 selects 100 kOhm and 11 selects 1 MOhm.
- R8: While `rst_ni` is low, `code_o` is 0, `shdn_o` is 0 and `pd_sel_o` is 00.
- R9: Frames are accepted whether `sclk_i` idles low or high between frames.
- R10: A valid mode-00 frame that arrives during shutdown leaves shutdown and loads the new code from that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; samples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cs_ni | input | 1 | Active-low chip select that frames a transfer |
| sclk_i | input | 1 | Serial clock; data is captured on its rising edge |
| din_i | input | 1 | Serial data, most significant bit first |
| code_o | output | 8 | Converter code presented to the switch array |
| shdn_o | output | 1 | High while in shutdown |
| pd_sel_o | output | 2 | Output pull-down select; 00 means no pull-down |

## Verification
Some properties are checked on every cycle. The bit counter never exceeds the frame length. The outputs stay fixed in every cycle without a commit. A commit happens only while the synchronized chip select is high. A mode-00 commit loads the code field and clears shutdown. Shutdown always forces the code output to zero. Other behaviour can only be shown by the bench's scenarios: serial bits land in the right field positions, the don't-care bits are ignored, both serial clock idle levels work, short and long frames are rejected, and leaving shutdown loads the new code.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_PD_LOW  = 2'b01,
    MODE_PD_MID  = 2'b10,
    MODE_PD_HIGH = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign rise_o[b] = q_o[b] & ~prev_q[b];
    assign fall_o[b] = ~q_o[b] & prev_q[b];
  end
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_low_i,
  input  logic                  cs_fall_i,
  input  logic                  cs_rise_i,
  input  logic                  sclk_rise_i,
  input  logic                  din_i,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  frame_ok_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      ovr_q   <= 1'b0;
    end else if (cs_fall_i || cs_rise_i) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (cs_low_i && sclk_rise_i) begin
      if (cnt_q == CNT_FULL) begin
        ovr_q <= 1'b1;  // extra clock poisons the frame
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        shreg_q <= {shreg_q[FRAME_BITS-2:0], din_i};
      end
    end
  end

  assign word_o     = shreg_q;
  assign frame_ok_o = cs_rise_i && (cnt_q == CNT_FULL) && !ovr_q;

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL); // R4
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_low_i && !cs_fall_i) |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/dac_cmd_latch.sv
module dac_cmd_latch
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned MODE_LSB   = 12,
  parameter int unsigned CODE_LSB   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_ok_i,
  input  logic [FRAME_BITS-1:0] word_i,
  output logic [CODE_W-1:0]     code_o,
  output logic                  shdn_o,
  output logic [1:0]            pd_sel_o
);
  pwr_mode_e         mode_q, word_mode;
  logic [CODE_W-1:0] code_q;

  assign word_mode = pwr_mode_e'(word_i[MODE_LSB +: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      code_q <= '0;
    end else if (frame_ok_i) begin
      mode_q <= word_mode;
      // code is retained through shutdown
      if (word_mode == MODE_RUN) code_q <= word_i[CODE_LSB +: CODE_W];
    end
  end

  assign shdn_o   = (mode_q != MODE_RUN);
  assign pd_sel_o = mode_q;
  assign code_o   = shdn_o ? '0 : code_q;

  AST_HOLD_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ok_i |=> ($stable(code_o) && $stable(pd_sel_o) && $stable(shdn_o))); // R2
  AST_LOAD_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok_i && word_i[MODE_LSB +: 2] == 2'b00)
      |=> (code_o == $past(word_i[CODE_LSB +: CODE_W]) && !shdn_o)); // R6
  AST_SHDN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_o |-> (code_o == '0 && pd_sel_o != 2'b00)); // R7
endmodule

// File: rtl/serial_dac_ctrl.sv
module serial_dac_ctrl #(
  parameter int unsigned FRAME_BITS  = 16,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [CODE_W-1:0] code_o,
  output logic              shdn_o,
  output logic [1:0]        pd_sel_o
);
  localparam int unsigned MODE_LSB = FRAME_BITS - 4;
  localparam int unsigned CODE_LSB = MODE_LSB - CODE_W;
  // bit order in sync vector: {cs, sclk, din}; cs idles high
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0]            pin_q, pin_rise, pin_fall;
  logic [FRAME_BITS-1:0] word;
  logic                  frame_ok;

  dac_in_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, din_i}),
    .q_o    (pin_q),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  dac_frame_shifter #(
    .FRAME_BITS (FRAME_BITS)
  ) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_low_i    (~pin_q[2]),
    .cs_fall_i   (pin_fall[2]),
    .cs_rise_i   (pin_rise[2]),
    .sclk_rise_i (pin_rise[1]),
    .din_i       (pin_q[0]),
    .word_o      (word),
    .frame_ok_o  (frame_ok)
  );

  dac_cmd_latch #(
    .FRAME_BITS (FRAME_BITS),
    .CODE_W     (CODE_W),
    .MODE_LSB   (MODE_LSB),
    .CODE_LSB   (CODE_LSB)
  ) i_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ok_i (frame_ok),
    .word_i     (word),
    .code_o     (code_o),
    .shdn_o     (shdn_o),
    .pd_sel_o   (pd_sel_o)
  );

  AST_COMMIT_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok |-> pin_q[2]); // R2
endmodule

// File: tb/test_serial_dac_ctrl.sv
module test_serial_dac_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       din = 1'b0;
  logic [7:0] code;
  logic       shdn;
  logic [1:0] pd_sel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  serial_dac_ctrl i_serial_dac_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cs_ni    (cs_n),
    .sclk_i   (sclk),
    .din_i    (din),
    .code_o   (code),
    .shdn_o   (shdn),
    .pd_sel_o (pd_sel)
  );

  // {word[32:17], nbits[16:12], sclk_idle_high[11], code[10:3], shdn[2], pd[1:0]}
  localparam int NV = 11;
  localparam logic [32:0] VEC [NV] = '{
    {16'h0A50, 5'd16, 1'b0, 8'hA5, 1'b0, 2'b00},  // R6 R1
    {16'hCFF7, 5'd16, 1'b1, 8'hFF, 1'b0, 2'b00},  // R5 R9 don't-care bits set
    {16'h0010, 5'd16, 1'b0, 8'h01, 1'b0, 2'b00},  // R6
    {16'h1230, 5'd16, 1'b0, 8'h00, 1'b1, 2'b01},  // R7 1k
    {16'h2000, 5'd16, 1'b1, 8'h00, 1'b1, 2'b10},  // R7 100k
    {16'h3FFF, 5'd16, 1'b1, 8'h00, 1'b1, 2'b11},  // R7 1M
    {16'h0800, 5'd16, 1'b0, 8'h80, 1'b0, 2'b00},  // R10 leave shutdown
    {16'h0330, 5'd15, 1'b0, 8'h80, 1'b0, 2'b00},  // R3 short frame
    {16'h1440, 5'd17, 1'b1, 8'h80, 1'b0, 2'b00},  // R4 long frame
    {16'h1000, 5'd0,  1'b0, 8'h80, 1'b0, 2'b00},  // R3 empty frame
    {16'h07F0, 5'd16, 1'b1, 8'h7F, 1'b0, 2'b00}   // R9 R6
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [7:0] c, input logic s, input logic [1:0] p);
    chk({req, " code"}, {8'h0, code}, {8'h0, c});
    chk({req, " shdn"}, {15'h0, shdn}, {15'h0, s});
    chk({req, " pd_sel"}, {14'h0, pd_sel}, {14'h0, p});
  endtask

  // opens a frame and clocks nbits; chip select left low
  task automatic shift_bits(input logic [15:0] w, input int nbits, input logic idle_hi);
    sclk = idle_hi;
    wait_clk(5);
    cs_n = 1'b0;
    wait_clk(5);
    for (int i = 0; i < nbits; i++) begin
      if (idle_hi) sclk = 1'b0;
      din = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(5);
      sclk = 1'b1;
      wait_clk(5);
      if (!idle_hi) sclk = 1'b0;
    end
    wait_clk(5);
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits, input logic idle_hi);
    shift_bits(w, nbits, idle_hi);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    check_out("R8 in reset", 8'h00, 1'b0, 2'b00);
    rst_n = 1'b1;
    wait_clk(5);
    check_out("R8 after release", 8'h00, 1'b0, 2'b00);

    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][32:17], int'(VEC[v][16:12]), VEC[v][11]);
      check_out($sformatf("vec%0d", v), VEC[v][10:3], VEC[v][2], VEC[v][1:0]);
    end

    // R1: toggling sclk/din with chip select high does nothing
    for (int i = 0; i < 20; i++) begin
      din = i[0];
      sclk = ~sclk;
      wait_clk(5);
    end
    sclk = 1'b0;
    wait_clk(5);
    check_out("R1 cs high", 8'h7F, 1'b0, 2'b00);

    // R2: full word in, chip select still low -> unchanged
    shift_bits(16'h0C30, 16, 1'b0);
    check_out("R2 before commit", 8'h7F, 1'b0, 2'b00);
    cs_n = 1'b1;
    wait_clk(10);
    check_out("R2 after commit", 8'hC3, 1'b0, 2'b00);

    // R10: shutdown then a run frame with new code
    send_frame(16'h2AA0, 16, 1'b0);
    check_out("R7 shutdown", 8'h00, 1'b1, 2'b10);
    send_frame(16'h03C0, 16, 1'b1);
    check_out("R10 resume", 8'h3C, 1'b0, 2'b00);

    // R8: async reset from shutdown
    send_frame(16'h1000, 16, 1'b0);
    rst_n = 1'b0;
    wait_clk(2);
    check_out("R8 reset from shutdown", 8'h00, 1'b0, 2'b00);
    rst_n = 1'b1;
    wait_clk(5);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule